// File: doc/BRIEF.md
# Reloading BCD Watchdog Countdown

This block is a watchdog timer whose period is held as four packed BCD digits, from 00.01 to 99.99 seconds, in two byte-wide bus registers. Once per 100 Hz tick enable the live count drops by one hundredth of a second, borrowing digit by digit. The tick that takes the count through 00.01 is an expiry. At expiry the block raises a one-clock raw alarm request and sets the watchdog flag. The live count then reloads from the programmed value, so if software stays silent the alarm keeps repeating.

Software holds the alarm off by touching either period register. A read restarts the countdown just as a write does. A touch also clears the flag. Reads always return the programmed period, and the live count cannot be seen. A period of 00.00 turns the watchdog off. The flag is either held until the next touch (level mode) or shown for a fixed number of clocks (pulse mode). The interrupt output is the flag gated by a mask input. Routing to physical pins and pad drive belong to the surrounding logic.

Top module: `wdg_bcd_watchdog`

## Requirements
- R1: After reset, both period registers read 0x00, the watchdog is disabled, and alarm_req, wdg_flag and wdg_irq are 0.
- R2: Address BASE_ADDR (default 0xC) reads and writes the fractional byte: tenths in bits 7:4, hundredths in bits 3:0. Address BASE_ADDR+1 (0xD) holds the seconds: tens in bits 7:4, units in bits 3:0. The two bytes may be written in either order. All other addresses read 0x00 and have no effect. The live count never appears on bus_rdata.
- R3: A read or a write of either period register reloads the countdown at that clock edge and clears wdg_flag. After a write, the reload value includes the byte just written. A touch in the same cycle as a tick wins, and that tick is lost.
- R4: Each tick lowers the count by 00.01 with BCD borrow through all four digits. Expiry comes on exactly the N-th tick after a touch, where N is the programmed period in hundredths.
- R5: At expiry, alarm_req is 1 for one clock, and the countdown reloads so that expiry repeats every N ticks until the next touch.
- R6: With cfg_pulse = 0, wdg_flag rises with alarm_req and stays 1 until the next touch.
- R7: With cfg_pulse = 1, wdg_flag rises with alarm_req and is 1 for exactly PULSE_CYCLES clocks, then returns to 0.
- R8: wdg_irq equals wdg_flag when cfg_mask = 0 and is 0 when cfg_mask = 1.
- R9: With a period of 00.00 no expiry occurs: alarm_req and wdg_flag stay 0 whatever ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_100hz | input | 1 | One-clock enable at 100 Hz |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cfg_pulse | input | 1 | 1 selects pulse mode, 0 level mode |
| cfg_mask | input | 1 | 1 blocks wdg_irq |
| alarm_req | output | 1 | Raw one-clock expiry request |
| wdg_flag | output | 1 | Watchdog flag (read-only status) |
| wdg_irq | output | 1 | Masked interrupt level or pulse |

## Verification
Short periods such as 00.05 and 00.03 run repeated expiries back to back. These separate a correct reload-and-repeat from a one-shot timer or an off-by-one period. The period 01.00 forces a borrow across three digits, and measuring 100 ticks between touch and alarm exposes faulty BCD borrow. Reads, writes and unmapped accesses arrive while ticks keep running. This tells kicking by reads apart from kicking by writes only, and shows whether a same-cycle touch beats a tick. Level, pulse, masked and zero-period runs each isolate one output path.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef logic [3:0] bcd_digit_t;

  localparam bcd_digit_t BCD_ZERO = 4'd0;
  localparam bcd_digit_t BCD_NINE = 4'd9;

  // One BCD digit lowered by one when borrow_in is set; wraps 0 -> 9
  function automatic bcd_digit_t bcd_digit_dec(input bcd_digit_t d, input logic borrow_in);
    bcd_digit_t r;
    if (!borrow_in)          r = d;
    else if (d == BCD_ZERO)  r = BCD_NINE;
    else                     r = d - 4'd1;
    return r;
  endfunction

endpackage

// File: rtl/wdg_prog_regs.sv
module wdg_prog_regs #(
  parameter int ADDR_W    = 4,
  parameter int DIGITS    = 4,
  parameter int BASE_ADDR = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  output logic [4*DIGITS-1:0] prog_q,
  output logic [4*DIGITS-1:0] prog_next,
  output logic                kick,
  output logic                wr_hit,
  output logic [7:0]          rdata
);
  localparam int NBYTES  = DIGITS / 2;
  localparam int COUNT_W = 4 * DIGITS;

  logic [NBYTES-1:0] byte_hit;

  // Byte lanes: address decode and write merge per lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign byte_hit[b] = (bus_addr == ADDR_W'(BASE_ADDR + b));
    assign prog_next[b*8 +: 8] = (bus_wr && byte_hit[b]) ? bus_wdata : prog_q[b*8 +: 8];
  end

  assign kick   = (|byte_hit) && (bus_wr || bus_rd);
  assign wr_hit = (|byte_hit) && bus_wr;

  // Read path shows only the programmed period
  always_comb begin
    rdata = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (byte_hit[b]) rdata = prog_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= '0;
    else        prog_q <= prog_next;
  end

  // R2: a write to the low byte lands in the period register
  assert_low_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && byte_hit[0]) |=> (prog_q[7:0] == $past(bus_wdata)));

  // R2: a period register only changes through a write strobe
  assert_period_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(prog_q));

  logic unused_ok;
  assign unused_ok = ^{COUNT_W};
endmodule

// File: rtl/wdg_bcd_down.sv
module wdg_bcd_down
  import wdg_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic [4*DIGITS-1:0] reload_val,
  input  logic                tick,
  input  logic                enable,
  output logic                expire
);
  localparam int COUNT_W = 4 * DIGITS;

  logic [COUNT_W-1:0] cnt_q, cnt_next, dec_val;
  logic [DIGITS-1:0]  borrow;
  logic               at_last;

  // Borrow chain: digit 0 always decrements, higher digits on underflow below
  assign borrow[0] = 1'b1;
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign dec_val[g*4 +: 4] = bcd_digit_dec(cnt_q[g*4 +: 4], borrow[g]);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] && (cnt_q[g*4 +: 4] == BCD_ZERO);
    end
  end

  // Count is 00.01 (or 00.00): this tick ends the period
  assign at_last = (cnt_q[COUNT_W-1:1] == '0);
  assign expire  = tick && enable && !kick && at_last;

  always_comb begin
    cnt_next = cnt_q;
    if (kick)                 cnt_next = load_val;
    else if (tick && enable)  cnt_next = at_last ? reload_val : dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  // R3: a touch restarts from the (possibly just written) period
  assert_kick_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(load_val)));

  // R5: expiry reloads the period for the next round
  assert_expire_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_val)));

  // R4: a tick in mid-count always moves the count
  assert_tick_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !kick && !at_last) |=> (cnt_q != $past(cnt_q)));

  // R9: with the timer off and no touch, the count is frozen
  assert_off_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !kick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm #(
  parameter int PULSE_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic kick,
  input  logic pulse_mode,
  input  logic mask,
  output logic alarm_req,
  output logic flag,
  output logic irq
);
  localparam int PCNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PCNT_W-1:0] PCNT_LOAD = PCNT_W'(PULSE_CYCLES - 1);

  logic              req_q, req_next;
  logic              flag_q, flag_next;
  logic [PCNT_W-1:0] pcnt_q, pcnt_next;

  always_comb begin
    req_next  = expire;
    flag_next = flag_q;
    pcnt_next = pcnt_q;
    if (kick) begin
      flag_next = 1'b0;
    end else if (expire) begin
      flag_next = 1'b1;
      pcnt_next = PCNT_LOAD;
    end else if (flag_q && pulse_mode) begin
      if (pcnt_q == '0) flag_next = 1'b0;
      else              pcnt_next = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      req_q  <= req_next;
      flag_q <= flag_next;
      pcnt_q <= pcnt_next;
    end
  end

  assign alarm_req = req_q;
  assign flag      = flag_q;
  assign irq       = flag_q && !mask;

  // R3: any touch clears the flag
  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !flag_q);

  // R6: level mode holds the flag until a touch
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !pulse_mode && !kick) |=> flag_q);

  // R7: pulse ends once its down-counter is spent
  assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && pulse_mode && !kick && !expire && pcnt_q == '0) |=> !flag_q);

  // R5: the raw request and the flag rise together
  assert_req_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> flag_q);
endmodule

// File: rtl/wdg_bcd_watchdog.sv
module wdg_bcd_watchdog #(
  parameter int ADDR_W       = 4,
  parameter int DIGITS       = 4,
  parameter int BASE_ADDR    = 12,
  parameter int PULSE_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cfg_pulse,
  input  logic              cfg_mask,
  output logic              alarm_req,
  output logic              wdg_flag,
  output logic              wdg_irq
);
  localparam int COUNT_W = 4 * DIGITS;

  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [COUNT_W-1:0] prog_q, prog_next;
  logic               kick, wr_hit, expire, enable;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wdg_prog_regs #(
    .ADDR_W(ADDR_W), .DIGITS(DIGITS), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .prog_q(prog_q), .prog_next(prog_next),
    .kick(kick), .wr_hit(wr_hit), .rdata(bus_rdata)
  );

  assign enable = |prog_q;

  wdg_bcd_down #(.DIGITS(DIGITS)) u_count (
    .clk(clk), .rst_n(rst_n_s),
    .kick(kick), .load_val(prog_next), .reload_val(prog_q),
    .tick(tick_100hz), .enable(enable), .expire(expire)
  );

  wdg_alarm #(.PULSE_CYCLES(PULSE_CYCLES)) u_alarm (
    .clk(clk), .rst_n(rst_n_s),
    .expire(expire), .kick(kick),
    .pulse_mode(cfg_pulse), .mask(cfg_mask),
    .alarm_req(alarm_req), .flag(wdg_flag), .irq(wdg_irq)
  );

  // R9: a zero period left unwritten never produces a request
  assert_zero_period_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(prog_q) == '0 && !$past(wr_hit)) |-> !alarm_req);

  // R8: a set mask keeps the interrupt low
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_mask |-> !wdg_irq);
endmodule

// File: tb/sim_wdg_bcd_watchdog.sv
module sim_wdg_bcd_watchdog;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       cfg_pulse = 1'b0, cfg_mask = 1'b0;
  logic [7:0] bus_rdata;
  logic       alarm_req, wdg_flag, wdg_irq;

  int errors = 0, checks = 0;
  bit tick_on = 1'b0;
  int tick_div = 0;

  always #10 clk = ~clk;

  wdg_bcd_watchdog #(.PULSE_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_pulse(cfg_pulse), .cfg_mask(cfg_mask),
    .alarm_req(alarm_req), .wdg_flag(wdg_flag), .wdg_irq(wdg_irq)
  );

  function automatic int bcd2int(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] int2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: period and count as decimal hundredths
  int  m_prog = 0, m_cnt = 0, m_pc = 0;
  bit  m_flag = 0, m_req = 0;
  int  tk = 0;           // ticks since last touch
  int  req_seen = 0;     // alarm_req count at negedges

  always @(posedge clk) begin
    bit hit, set;
    int np;
    if (!rst_n) begin
      m_prog = 0; m_cnt = 0; m_pc = 0; m_flag = 0; m_req = 0; tk = 0;
    end else begin
      hit = (bus_wr || bus_rd) && (bus_addr == 4'hC || bus_addr == 4'hD);
      np = m_prog;
      if (bus_wr && bus_addr == 4'hC) np = (m_prog / 100) * 100 + bcd2int(bus_wdata);
      if (bus_wr && bus_addr == 4'hD) np = bcd2int(bus_wdata) * 100 + m_prog % 100;
      m_req = 0;
      if (hit) begin
        m_cnt = np; m_flag = 0; tk = 0;
      end else begin
        set = 0;
        if (tick_100hz) tk++;
        if (tick_100hz && m_prog != 0) begin
          if (m_cnt <= 1) begin m_cnt = m_prog; m_req = 1; set = 1; end
          else m_cnt = m_cnt - 1;
        end
        if (set) begin m_flag = 1; m_pc = P - 1; end
        else if (m_flag && cfg_pulse) begin
          if (m_pc == 0) m_flag = 0; else m_pc--;
        end
      end
      m_prog = np;
    end
  end

  // Compare on every clock, mid-cycle
  always @(negedge clk) begin
    logic [7:0] exp_rd;
    if (rst_n) begin
      exp_rd = (bus_addr == 4'hC) ? int2bcd(m_prog % 100) :
               (bus_addr == 4'hD) ? int2bcd(m_prog / 100) : 8'h00;
      check("R2 rdata", int'(bus_rdata), int'(exp_rd));
      check("R5 alarm_req", int'(alarm_req), int'(m_req));
      check("R6 flag", int'(wdg_flag), int'(m_flag));
      check("R8 irq", int'(wdg_irq), int'(m_flag && !cfg_mask));
      if (alarm_req) req_seen++;
    end
  end

  // Tick generator: one tick every third clock when enabled
  always @(posedge clk) begin
    #2;
    if (tick_on && tick_div == 2) begin tick_100hz = 1'b1; tick_div = 0; end
    else begin tick_100hz = 1'b0; if (tick_on) tick_div++; end
  end

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2; bus_wr = 1'b0;
  endtask
  task automatic bus_read(input logic [3:0] a);
    @(posedge clk); #2; bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #2; bus_rd = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int width, r0;
    idle(3); #2 rst_n = 1'b1; idle(4);

    // R1: reset state
    @(negedge clk); bus_addr = 4'hC; #1;
    check("R1 rdata C", int'(bus_rdata), 0);
    bus_addr = 4'hD; #1;
    check("R1 rdata D", int'(bus_rdata), 0);
    check("R1 flag", int'(wdg_flag), 0);
    check("R1 req", int'(alarm_req), 0);

    // R9: reset leaves the timer off even with ticks
    tick_on = 1'b1; r0 = req_seen; idle(200);
    check("R9 no alarm after reset", req_seen - r0, 0);

    // R5/R6: 00.05 level mode, repeating
    bus_write(4'hD, 8'h00); bus_write(4'hC, 8'h05);
    r0 = req_seen; idle(3 * 5 * 6 + 2);
    check("R5 repeats", (req_seen - r0 >= 5) ? 1 : 0, 1);
    @(negedge clk); check("R6 flag held", int'(wdg_flag), 1);

    // R3: a read clears the flag and restarts
    bus_read(4'hD);
    @(negedge clk); check("R3 read clears flag", int'(wdg_flag), 0);

    // R8: mask blocks the interrupt
    cfg_mask = 1'b1; idle(40);
    @(negedge clk); check("R8 masked irq", int'(wdg_irq), 0);
    cfg_mask = 1'b0;

    // R2: unmapped address reads zero, no kick
    bus_read(4'h5); bus_write(4'h3, 8'h77);
    @(negedge clk); bus_addr = 4'h3; #1;
    check("R2 unmapped read", int'(bus_rdata), 0);

    // R4: 01.00 needs borrow across digits; period is 100 ticks
    bus_write(4'hC, 8'h00); bus_write(4'hD, 8'h01);
    @(negedge clk); bus_addr = 4'hD; #1;
    check("R2 readback D", int'(bus_rdata), 8'h01);
    while (!alarm_req) @(negedge clk);
    check("R4 period 01.00 ticks", tk, 100);

    // R7: pulse mode width
    cfg_pulse = 1'b1;
    bus_write(4'hD, 8'h00); bus_write(4'hC, 8'h03);
    @(negedge clk); while (!wdg_flag) @(negedge clk);
    width = 0;
    while (wdg_flag) begin width++; @(negedge clk); end
    check("R7 pulse width", width, P);
    idle(60);
    cfg_pulse = 1'b0;

    // R3: touches running at tick rate hold the alarm off
    bus_write(4'hC, 8'h04);
    r0 = req_seen;
    for (int i = 0; i < 20; i++) begin bus_read(4'hC); idle(6); end
    check("R3 periodic touch no alarm", req_seen - r0, 0);

    // R9: writing 00.00 disables
    bus_write(4'hC, 8'h00);
    r0 = req_seen; idle(400);
    check("R9 zero period quiet", req_seen - r0, 0);
    @(negedge clk); check("R9 flag low", int'(wdg_flag), 0);

    finish_run();
  end
endmodule